// File: doc/BRIEF.md
# Paged Address Translation Unit

This block converts the virtual addresses issued by a processor into physical addresses. The virtual address is split into a page number and a 12-bit byte offset. A page number is first looked up in a small fully associative translation cache. On a hit, the frame number comes straight from the cache and no page table memory access is made. On a miss, a hardware walker reads one page table entry from a word-addressed memory through a request/response port. The entry's word address is the table base plus the page number.

The walker runs its checks in a fixed order, so that an access violation and a missing resident page are always told apart. The order is: does an entry exist, is the page mapped into the address space, is the access allowed for the current mode, and is the page resident in a frame. The first check that fails sets the fault code of the response. Only translations that pass every check are written into the cache. A faulting request leaves nothing behind, so the same access can be retried once the operating system has repaired the entry. Loading a new table base and pulsing the flush input both empty the cache, which is what a context switch requires.

The control path is one state machine with these states:
- IDLE accepts a request and moves to LOOKUP.
- LOOKUP goes to RESP on a cache hit or on a page number outside the table. Otherwise it goes to WALK_REQ.
- WALK_REQ holds the memory request until it is accepted, then moves to WALK_WAIT.
- WALK_WAIT waits for the memory response, then moves to CHECK.
- CHECK goes to REFILL when the entry passed every check and no flush arrived during the walk. Otherwise it goes directly to RESP.
- REFILL writes the cache, then moves to RESP.
- RESP presents the result for one cycle and returns to IDLE.

Top module: `mmu_xlate`

## Requirements
- R1: A successful translation returns a physical address whose upper 20 bits are the frame number, taken from entry bits 26:7. The lower 12 bits are the virtual address bits 11:0, unchanged.
- R2: A cache hit makes no memory request. rsp_valid is high on the second rising edge after the edge that accepted the request.
- R3: A cache miss on a page number below 2^PT_IDX_W issues exactly one memory read, at word address base + page number, where the page number is virtual address bits 31:12. That translation is then cached, so a later change to the entry in memory is not seen until a flush.
- R4: Fault codes are: 0 none, 1 no entry, 2 not mapped, 3 protection, 4 not present. rsp_fault is high exactly when the code is nonzero. A page number of 2^PT_IDX_W or more gives code 1 with no memory read. Entry bit 0 clear gives code 1. Otherwise, bit 1 clear gives code 2. Otherwise, a failed permission check gives code 3. Otherwise, bit 2 clear gives code 4. The first failing check wins.
- R5: Access type codes are 0 read, 1 write and 2 execute; code 3 is never allowed. Each type is permitted by entry bit 3, bit 4 or bit 5 respectively. A user-mode access (req_user = 1) also needs bit 6 set. Kernel mode ignores bit 6. The permission check is also applied on a cache hit.
- R6: A request that faults is not cached. Retrying it after the entry has been repaired makes a new memory read and succeeds.
- R7: Pulsing flush or writing the base register empties the cache. The next access to any page walks the table at the current base.
- R8: A flush during the lookup cycle forces a miss, even if the page was cached.
- R9: A flush that arrives while a walk is in flight does not stop the response. The translation it produced is not cached.
- R10: Two virtual pages that map to the same frame are both translated to that frame, on the miss path and on the hit path.
- R11: The cache holds 8 translations, filled in round-robin order starting from slot 0 after a flush. A ninth distinct page replaces the oldest fill and leaves the other seven cached.
- R12: After reset, req_ready is high and both rsp_valid and mem_req_valid are low. req_ready stays low from acceptance until the response, so only one request is ever outstanding. rsp_valid is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle, request accepted on this edge |
| req_vaddr | input | VA_W (32) | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | PA_W (32) | Physical address, zero on a fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_code | output | 3 | Fault code |
| mem_req_valid | output | 1 | Page table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | MEM_AW (16) | Word address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | PTE_W (27) | Page table entry |
| base_we | input | 1 | Load the table base register, flushes the cache |
| base_wdata | input | MEM_AW (16) | New table base |
| flush | input | 1 | Invalidate every cache entry |

## Verification
The bench deliberately builds entries that fail several checks at once. A read-only, non-resident page accessed with a write must report a protection fault, not a page fault. A design that checks residency too early would misreport it. It also times flushes to land exactly in the lookup cycle and in the middle of a walk. A cache that ignores the same-cycle flush, or that refills after a mid-walk flush, keeps serving a stale frame, and the bench sees that frame after editing the table. The bench further fills the cache past its capacity, where a wrong victim pointer shows up as an unexpected memory read. It checks that permissions on a cached kernel-only page still block a user access. Finally, it checks that a faulted entry is re-read after repair rather than cached.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WALK_REQ,
        ST_WALK_WAIT,
        ST_CHECK,
        ST_REFILL,
        ST_RESP
    } xl_state_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_NO_ENTRY = 3'd1,
        FLT_UNMAPPED = 3'd2,
        FLT_PROT     = 3'd3,
        FLT_ABSENT   = 3'd4
    } fault_e;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    // entry flag positions
    localparam int PTE_EXIST  = 0;
    localparam int PTE_MAPPED = 1;
    localparam int PTE_RESID  = 2;
    localparam int PTE_PERM_LSB  = 3;   // four permission bits: r, w, x, user
    localparam int PTE_FRAME_LSB = 7;

    // permission nibble layout as stored in the cache
    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;
    localparam int PERM_U = 3;

    function automatic logic perm_ok(input logic [3:0] perm,
                                     input logic [1:0] acc,
                                     input logic       user);
        logic type_ok;
        unique case (acc)
            ACC_READ:  type_ok = perm[PERM_R];
            ACC_WRITE: type_ok = perm[PERM_W];
            ACC_EXEC:  type_ok = perm[PERM_X];
            default:   type_ok = 1'b0;
        endcase
        return type_ok && (!user || perm[PERM_U]);
    endfunction

endpackage

// File: rtl/mmu_pte_check.sv
module mmu_pte_check
    import mmu_pkg::*;
#(
    parameter int FRAME_W = 20,
    localparam int PTE_W  = FRAME_W + PTE_FRAME_LSB
) (
    input  logic [PTE_W-1:0]   pte,
    input  logic [1:0]         acc,
    input  logic               user,
    output fault_e             code,
    output logic [FRAME_W-1:0] frame,
    output logic [3:0]         perm
);

    assign perm  = pte[PTE_PERM_LSB +: 4];
    assign frame = pte[PTE_FRAME_LSB +: FRAME_W];

    // ordered checks: existence, mapping, protection, residency
    always_comb begin
        if (!pte[PTE_EXIST]) begin
            code = FLT_NO_ENTRY;
        end else if (!pte[PTE_MAPPED]) begin
            code = FLT_UNMAPPED;
        end else if (!perm_ok(perm, acc, user)) begin
            code = FLT_PROT;
        end else if (!pte[PTE_RESID]) begin
            code = FLT_ABSENT;
        end else begin
            code = FLT_NONE;
        end
    end

endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int FRAME_W = 20,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    output logic [3:0]         lk_perm,
    input  logic               wr_en,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic [3:0]         wr_perm,
    output logic [ENTRIES-1:0] vmask
);

    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   tag_q   [ENTRIES];
    logic [FRAME_W-1:0] frame_q [ENTRIES];
    logic [3:0]         perm_q  [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   ptr_q;

    assign vmask = vld_q;

    // round-robin victim pointer, restarted by a flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr_q <= '0;
        end else if (wr_en) begin
            ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);

        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld_q[g] <= 1'b0;
            end else if (wr_en && ptr_q == IDX_W'(g)) begin
                vld_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && !flush && ptr_q == IDX_W'(g)) begin
                tag_q[g]   <= wr_vpn;
                frame_q[g] <= wr_frame;
                perm_q[g]  <= wr_perm;
            end
        end
    end

    // a flush in the lookup cycle wins over any match
    assign lk_hit = (|match) && !flush;

    always_comb begin
        lk_frame = '0;
        lk_perm  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_frame = lk_frame | frame_q[i];
                lk_perm  = lk_perm  | perm_q[i];
            end
        end
    end

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PAGE_BITS   = 12,
    parameter int PT_IDX_W    = 6,
    parameter int TLB_ENTRIES = 8,
    parameter int FRAME_W     = 20,
    parameter int MEM_AW      = 16,
    localparam int VPN_W      = VA_W - PAGE_BITS,
    localparam int PA_W       = FRAME_W + PAGE_BITS,
    localparam int PTE_W      = FRAME_W + PTE_FRAME_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic [2:0]        rsp_code,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    input  logic              base_we,
    input  logic [MEM_AW-1:0] base_wdata,
    input  logic              flush
);

    xl_state_e state_q, state_d;

    logic [VPN_W-1:0]     vpn_q;
    logic [PAGE_BITS-1:0] off_q;
    logic [1:0]           acc_q;
    logic                 user_q;
    logic [MEM_AW-1:0]    base_q;
    logic [MEM_AW-1:0]    maddr_q;
    logic [PTE_W-1:0]     pte_q;
    logic                 stale_q;
    logic [PA_W-1:0]      res_paddr_q;
    fault_e               res_code_q;

    logic                 inv_all;
    logic                 in_range;
    logic                 lk_hit;
    logic [FRAME_W-1:0]   lk_frame;
    logic [3:0]           lk_perm;
    fault_e               chk_code;
    logic [FRAME_W-1:0]   chk_frame;
    logic [3:0]           chk_perm;
    logic                 fill_en;
    logic [TLB_ENTRIES-1:0] tlb_vmask;

    assign inv_all  = flush || base_we;
    assign in_range = (vpn_q[VPN_W-1:PT_IDX_W] == '0);
    assign fill_en  = (state_q == ST_REFILL);

    mmu_tlb #(
        .ENTRIES (TLB_ENTRIES),
        .VPN_W   (VPN_W),
        .FRAME_W (FRAME_W)
    ) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (inv_all),
        .lk_vpn   (vpn_q),
        .lk_hit   (lk_hit),
        .lk_frame (lk_frame),
        .lk_perm  (lk_perm),
        .wr_en    (fill_en),
        .wr_vpn   (vpn_q),
        .wr_frame (chk_frame),
        .wr_perm  (chk_perm),
        .vmask    (tlb_vmask)
    );

    mmu_pte_check #(
        .FRAME_W (FRAME_W)
    ) u_check (
        .pte   (pte_q),
        .acc   (acc_q),
        .user  (user_q),
        .code  (chk_code),
        .frame (chk_frame),
        .perm  (chk_perm)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (lk_hit || !in_range) state_d = ST_RESP;
                else                     state_d = ST_WALK_REQ;
            end
            ST_WALK_REQ: begin
                if (mem_req_ready) state_d = ST_WALK_WAIT;
            end
            ST_WALK_WAIT: begin
                if (mem_rsp_valid) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (chk_code == FLT_NONE && !stale_q && !inv_all) state_d = ST_REFILL;
                else                                              state_d = ST_RESP;
            end
            ST_REFILL: state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // request capture and table base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            off_q  <= '0;
            acc_q  <= '0;
            user_q <= 1'b0;
            base_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                vpn_q  <= req_vaddr[VA_W-1:PAGE_BITS];
                off_q  <= req_vaddr[PAGE_BITS-1:0];
                acc_q  <= req_acc;
                user_q <= req_user;
            end
            if (base_we) begin
                base_q <= base_wdata;
            end
        end
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            maddr_q <= '0;
            pte_q   <= '0;
            stale_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_LOOKUP: begin
                    maddr_q <= base_q + MEM_AW'(vpn_q[PT_IDX_W-1:0]);
                    stale_q <= 1'b0;
                end
                ST_WALK_REQ: begin
                    if (inv_all) stale_q <= 1'b1;
                end
                ST_WALK_WAIT: begin
                    if (inv_all) stale_q <= 1'b1;
                    if (mem_rsp_valid) pte_q <= mem_rsp_data;
                end
                default: begin
                end
            endcase
        end
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_paddr_q <= '0;
            res_code_q  <= FLT_NONE;
        end else begin
            if (state_q == ST_LOOKUP) begin
                if (lk_hit) begin
                    if (perm_ok(lk_perm, acc_q, user_q)) begin
                        res_paddr_q <= {lk_frame, off_q};
                        res_code_q  <= FLT_NONE;
                    end else begin
                        res_paddr_q <= '0;
                        res_code_q  <= FLT_PROT;
                    end
                end else if (!in_range) begin
                    res_paddr_q <= '0;
                    res_code_q  <= FLT_NO_ENTRY;
                end
            end else if (state_q == ST_CHECK) begin
                res_code_q  <= chk_code;
                res_paddr_q <= (chk_code == FLT_NONE) ? {chk_frame, off_q} : '0;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        rsp_valid     = (state_q == ST_RESP);
        mem_req_valid = (state_q == ST_WALK_REQ);
        mem_req_addr  = maddr_q;
        rsp_paddr     = res_paddr_q;
        rsp_code      = res_code_q;
        rsp_fault     = (res_code_q != FLT_NONE);
    end

endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk #(
    parameter int VA_W        = 32,
    parameter int PAGE_BITS   = 12,
    parameter int PA_W        = 32,
    parameter int MEM_AW      = 16,
    parameter int TLB_ENTRIES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [VA_W-1:0]        req_vaddr,
    input logic                   rsp_valid,
    input logic [PA_W-1:0]        rsp_paddr,
    input logic                   rsp_fault,
    input logic [2:0]             rsp_code,
    input logic                   mem_req_valid,
    input logic                   mem_req_ready,
    input logic [MEM_AW-1:0]      mem_req_addr,
    input logic                   flush,
    input logic                   base_we,
    input logic [TLB_ENTRIES-1:0] tlb_vmask
);

    logic [PAGE_BITS-1:0] off_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_cap <= '0;
        end else if (req_valid && req_ready) begin
            off_cap <= req_vaddr[PAGE_BITS-1:0];
        end
    end

    a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r12_no_walk_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    a_r4_code_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_fault == (rsp_code != 3'd0)) && (rsp_code <= 3'd4)));

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[PAGE_BITS-1:0] == off_cap));

    a_r3_mem_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (flush || base_we) |=> (tlb_vmask == '0));

    a_r6_fault_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> ($countones(tlb_vmask) <= $countones($past(tlb_vmask))));

endmodule

bind mmu_xlate mmu_xlate_chk #(
    .VA_W        (VA_W),
    .PAGE_BITS   (PAGE_BITS),
    .PA_W        (PA_W),
    .MEM_AW      (MEM_AW),
    .TLB_ENTRIES (TLB_ENTRIES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_code      (rsp_code),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .flush         (flush),
    .base_we       (base_we),
    .tlb_vmask     (tlb_vmask)
);

// File: tb/tb_mmu_xlate.sv
module tb_mmu_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [2:0]  rsp_code;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [26:0] mem_rsp_data = '0;
    logic        base_we = 1'b0;
    logic [15:0] base_wdata = '0;
    logic        flush = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    mmu_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .base_we(base_we), .base_wdata(base_wdata), .flush(flush)
    );

    logic [26:0] pmem [256];
    int checks = 0;
    int failures = 0;
    int mem_reads = 0;
    int rsp_delay = 1;
    logic [15:0] last_addr = '0;
    bit finished = 1'b0;

    logic [31:0] r_pa;
    logic [2:0]  r_code;
    logic        r_fault;
    int          r_lat;
    int          r_reads;

    function automatic logic [26:0] mk(input logic [19:0] frame, input logic u, x, w, r, p, m, e);
        return {frame, u, x, w, r, p, m, e};
    endfunction

    function automatic logic [2:0] exp_code(input logic [26:0] pte, input int vpn,
                                            input logic [1:0] acc, input logic usr);
        logic ok;
        if (vpn > 63 || !pte[0]) return 3'd1;
        if (!pte[1]) return 3'd2;
        ok = (acc == 2'd0 && pte[3]) || (acc == 2'd1 && pte[4]) || (acc == 2'd2 && pte[5]);
        if (usr && !pte[6]) ok = 1'b0;
        if (!ok) return 3'd3;
        if (!pte[2]) return 3'd4;
        return 3'd0;
    endfunction

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // page table memory model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid && mem_req_ready) begin
                logic [26:0] d;
                mem_reads++;
                last_addr = mem_req_addr;
                d = pmem[mem_req_addr[7:0]];
                repeat (rsp_delay) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = d;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic xlate(input logic [31:0] va, input logic [1:0] acc, input logic usr);
        int r0;
        r0 = mem_reads;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_acc   = acc;
        req_user  = usr;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            r_lat++;
        end
        r_pa    = rsp_paddr;
        r_code  = rsp_code;
        r_fault = rsp_fault;
        r_reads = mem_reads - r0;
    endtask

    task automatic set_base(input logic [15:0] b);
        @(negedge clk);
        base_we = 1'b1;
        base_wdata = b;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic expect_ok(input string req, input logic [19:0] frame, input logic [11:0] off,
                             input int reads);
        chk(r_code == 3'd0 && !r_fault, req, "code", {29'd0, r_code}, 32'd0);
        chk(r_pa == {frame, off}, req, "paddr", r_pa, {frame, off});
        chk(r_reads == reads, req, "mem reads", r_reads, reads);
    endtask

    task automatic expect_fault(input string req, input logic [2:0] code, input int reads);
        chk(r_code == code && r_fault, req, "fault code", {28'd0, r_fault, r_code}, {28'd1, 1'b0, code});
        chk(r_reads == reads, req, "mem reads", r_reads, reads);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) pmem[i] = '0;

        repeat (3) @(negedge clk);
        // R12 reset state
        chk(req_ready === 1'b1, "R12", "req_ready after reset", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R12", "idle outputs after reset",
            {30'd0, rsp_valid, mem_req_valid}, 32'd0);
        rst_n = 1'b1;
        set_base(16'd0);

        // R1 / R3: miss walks base + vpn
        pmem[5] = mk(20'hABCDE, 1, 1, 1, 1, 1, 1, 1);
        xlate(32'h0000_5123, 2'd0, 1'b1);
        expect_ok("R3", 20'hABCDE, 12'h123, 1);
        chk(last_addr == 16'd5, "R3", "walk address", {16'd0, last_addr}, 32'd5);

        // R2: hit, no read, fixed latency; R1 offset pass-through
        xlate(32'h0000_5FFF, 2'd1, 1'b1);
        expect_ok("R1", 20'hABCDE, 12'hFFF, 0);
        chk(r_lat == 2, "R2", "hit latency", r_lat, 2);

        // R4 ordered faults
        xlate(32'h0004_6000, 2'd0, 1'b0);
        expect_fault("R4 out of range", 3'd1, 0);
        pmem[6] = mk(20'h12345, 1, 1, 1, 1, 1, 1, 0);
        xlate(32'h0000_6000, 2'd0, 1'b0);
        expect_fault("R4 no entry", 3'd1, 1);
        pmem[7] = mk(20'h12345, 0, 0, 0, 0, 0, 0, 1);
        xlate(32'h0000_7000, 2'd0, 1'b0);
        expect_fault("R4 unmapped", 3'd2, 1);
        pmem[8] = mk(20'h00808, 1, 0, 0, 1, 0, 1, 1);
        xlate(32'h0000_8000, 2'd1, 1'b0);
        expect_fault("R4 protection before residency", 3'd3, 1);
        xlate(32'h0000_8000, 2'd0, 1'b0);
        expect_fault("R4 not present", 3'd4, 1);

        // R6 repair and retry
        pmem[8] = mk(20'h00808, 1, 0, 0, 1, 1, 1, 1);
        xlate(32'h0000_8010, 2'd0, 1'b0);
        expect_ok("R6", 20'h00808, 12'h010, 1);

        // R5 permissions
        pmem[9] = mk(20'h09009, 0, 0, 1, 1, 1, 1, 1);
        xlate(32'h0000_9000, 2'd0, 1'b1);
        expect_fault("R5 user on kernel page", 3'd3, 1);
        xlate(32'h0000_9004, 2'd0, 1'b0);
        expect_ok("R5 kernel read", 20'h09009, 12'h004, 1);
        xlate(32'h0000_9008, 2'd0, 1'b1);
        expect_fault("R5 user blocked on hit", 3'd3, 0);
        xlate(32'h0000_9008, 2'd2, 1'b0);
        expect_fault("R5 execute on rw page", 3'd3, 0);
        xlate(32'h0000_9008, 2'd3, 1'b0);
        expect_fault("R5 reserved access type", 3'd3, 0);

        // R7 caching, flush, base write
        pmem[5] = mk(20'h11111, 1, 1, 1, 1, 1, 1, 1);
        xlate(32'h0000_5000, 2'd0, 1'b0);
        expect_ok("R7 stale before flush", 20'hABCDE, 12'h000, 0);
        pulse_flush();
        xlate(32'h0000_5000, 2'd0, 1'b0);
        expect_ok("R7 after flush", 20'h11111, 12'h000, 1);
        pmem[128 + 5] = mk(20'h22222, 1, 1, 1, 1, 1, 1, 1);
        set_base(16'd128);
        xlate(32'h0000_5ABC, 2'd0, 1'b0);
        expect_ok("R7 new base", 20'h22222, 12'hABC, 1);
        chk(last_addr == 16'd133, "R7", "walk address at new base", {16'd0, last_addr}, 32'd133);

        // R8 flush in the lookup cycle
        fork
            xlate(32'h0000_5000, 2'd0, 1'b0);
            begin
                @(negedge clk);
                while (req_ready) @(negedge clk);
                flush = 1'b1;
                @(negedge clk);
                flush = 1'b0;
            end
        join
        expect_ok("R8", 20'h22222, 12'h000, 1);
        xlate(32'h0000_5000, 2'd0, 1'b0);
        expect_ok("R8 refilled", 20'h22222, 12'h000, 0);

        // R9 flush during walk
        pmem[128 + 12] = mk(20'h0C0C0, 1, 1, 1, 1, 1, 1, 1);
        rsp_delay = 3;
        fork
            xlate(32'h0000_C004, 2'd0, 1'b0);
            begin
                int r0;
                r0 = mem_reads;
                @(negedge clk);
                while (mem_reads == r0) @(negedge clk);
                @(negedge clk);
                flush = 1'b1;
                @(negedge clk);
                flush = 1'b0;
            end
        join
        rsp_delay = 1;
        expect_ok("R9 response", 20'h0C0C0, 12'h004, 1);
        xlate(32'h0000_C004, 2'd0, 1'b0);
        expect_ok("R9 not cached", 20'h0C0C0, 12'h004, 1);

        // R10 aliasing
        pmem[128 + 10] = mk(20'h33333, 1, 1, 1, 1, 1, 1, 1);
        pmem[128 + 11] = mk(20'h33333, 1, 1, 1, 1, 1, 1, 1);
        xlate(32'h0000_A111, 2'd0, 1'b1);
        expect_ok("R10 first alias", 20'h33333, 12'h111, 1);
        xlate(32'h0000_B222, 2'd0, 1'b1);
        expect_ok("R10 second alias", 20'h33333, 12'h222, 1);
        xlate(32'h0000_A333, 2'd1, 1'b1);
        expect_ok("R10 hit alias", 20'h33333, 12'h333, 0);
        xlate(32'h0000_B444, 2'd1, 1'b1);
        expect_ok("R10 hit alias", 20'h33333, 12'h444, 0);

        // R11 round-robin capacity
        for (int v = 20; v <= 28; v++) pmem[128 + v] = mk(20'(v * 3), 1, 1, 1, 1, 1, 1, 1);
        pulse_flush();
        for (int v = 20; v <= 27; v++) begin
            xlate({20'(v), 12'h000}, 2'd0, 1'b0);
            expect_ok("R11 fill", 20'(v * 3), 12'h000, 1);
        end
        for (int v = 20; v <= 27; v++) begin
            xlate({20'(v), 12'h010}, 2'd0, 1'b0);
            expect_ok("R11 all eight held", 20'(v * 3), 12'h010, 0);
        end
        xlate({20'd28, 12'h000}, 2'd0, 1'b0);
        expect_ok("R11 ninth page", 20'd84, 12'h000, 1);
        for (int v = 21; v <= 27; v++) begin
            xlate({20'(v), 12'h020}, 2'd0, 1'b0);
            expect_ok("R11 survivors", 20'(v * 3), 12'h020, 0);
        end
        xlate({20'd20, 12'h000}, 2'd0, 1'b0);
        expect_ok("R11 oldest evicted", 20'd60, 12'h000, 1);

        // random phase over a fresh table (R1 R3 R4 R5)
        for (int v = 0; v < 64; v++) begin
            logic [6:0] fl;
            fl = 7'($urandom);
            if ($urandom_range(0, 3) != 0) fl[2:0] = 3'b111;
            pmem[128 + v] = {20'($urandom), fl};
        end
        set_base(16'd128);
        for (int n = 0; n < 300; n++) begin
            int          vpn;
            logic [11:0] off;
            logic [1:0]  acc;
            logic        usr;
            logic [2:0]  ec;
            logic [26:0] pte;
            vpn = ($urandom_range(0, 9) == 0) ? int'($urandom_range(64, 1048575))
                                               : int'($urandom_range(0, 63));
            off = 12'($urandom);
            acc = 2'($urandom_range(0, 3));
            usr = 1'($urandom);
            rsp_delay = $urandom_range(1, 3);
            pte = (vpn < 64) ? pmem[128 + vpn] : 27'd0;
            xlate({20'(vpn), off}, acc, usr);
            ec = exp_code(pte, vpn, acc, usr);
            chk(r_code == ec && r_fault == (ec != 3'd0), "R4", "random fault code",
                {28'd0, r_fault, r_code}, {28'd0, ec != 3'd0, ec});
            if (ec == 3'd0)
                chk(r_pa == {pte[26:7], off}, "R1", "random paddr", r_pa, {pte[26:7], off});
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule